// File: doc/BRIEF.md
# Stepper Motor Phase Sequencer

This block produces the 8-bit coil pattern for a four-phase stepper motor. Each step request moves the motor one position forward or backward. In half-step mode there are eight positions per electrical cycle: single-coil patterns alternate with two-coil patterns. In full-step mode only the four two-coil patterns are used. Each 4-bit coil nibble is repeated in both halves of the output byte.

Position is kept as one 3-bit index into the eight-entry half-step cycle, and both modes share it. Full-step mode moves to the next or previous odd position. Because of this, changing the mode between steps never makes the rotor jump.

An auto mode issues steps from a programmable cycle counter, so the motor can run without a stream of external pulses.

Top module: `stepper_phase_seq`

## Requirements
- R1: After a synchronous active-low reset the output is 0x33 (index 1).
- R2: In half-step mode, forward steps give 0x11, 0x33, 0x22, 0x66, 0x44, 0xCC, 0x88, 0x99 for indices 0 to 7, wrapping from 0x99 to 0x11.
- R3: In half-step mode with `dir_rev`=1, each step moves to the previous entry of the R2 sequence, wrapping from 0x11 to 0x99.
- R4: In full-step mode, forward steps from an odd index cycle 0x33, 0x66, 0xCC, 0x99, then wrap to 0x33.
- R5: In full-step mode with `dir_rev`=1, the R4 cycle runs backwards, wrapping from 0x33 to 0x99.
- R6: In full-step mode at an even index, a step moves to the adjacent odd index in the chosen direction (from 0x22, forward gives 0x66 and reverse gives 0x33). The index is never skipped by more than one position.
- R7: With no step request and auto mode off, the output holds its value. Changing `dir_rev` or `half_mode` alone does not alter it.
- R8: With `auto_en`=1 and `rate`=N (N≥1), a step occurs on every N-th rising clock edge counted from the first edge at which `auto_en` is high.
- R9: A step request in the same cycle as an auto step produces exactly one step.
- R10: `rate`=0 behaves as `rate`=1, so auto mode steps every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step_req | input | 1 | Request one step on this edge |
| dir_rev | input | 1 | 0 = forward, 1 = reverse |
| half_mode | input | 1 | 1 = half-step, 0 = full-step |
| auto_en | input | 1 | Enable automatic stepping |
| rate | input | RATE_W | Auto step period in cycles |
| coils | output | 8 | Registered coil pattern |

## Verification
An external step request and an expiring auto-rate counter can fall on the same clock edge. The bench provokes this by holding `step_req` high while auto mode runs with a period of two. Some edges then carry both sources and the others carry only the request. The scoreboard expects exactly one half-step advance per edge in both cases, so any double advance or lost step shows up as a pattern mismatch.

// File: rtl/stepper_seq_pkg.sv
// Package: shared widths and the coil-pattern function of the sequencer.
// Assumes a four-phase motor whose nibble is mirrored in both output halves.
package stepper_seq_pkg;

    localparam int IDX_W  = 3;
    localparam int COIL_W = 4;

    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [COIL_W-1:0] nib_t;

    // Coil nibble for a half-step index.
    // Even index 2k energises coil k alone.
    // Odd index 2k+1 energises coils k and k+1 (mod 4).
    function automatic nib_t coil_nibble(input idx_t idx);
        nib_t one;
        one = nib_t'(1) << idx[2:1];
        if (idx[0])
            return one | {one[COIL_W-2:0], one[COIL_W-1]};
        else
            return one;
    endfunction

endpackage

// File: rtl/stepper_rate_div.sv
// Module: programmable auto-step divider.
// Emits a one-cycle tick on every RATE-th enabled edge.
// Assumes rate 0 is treated as 1. The count restarts whenever the divider is disabled.
module stepper_rate_div #(
    parameter int RATE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [RATE_W-1:0] rate,
    output logic              tick
);
    logic [RATE_W-1:0] cnt_q;
    logic [RATE_W-1:0] limit;

    // Effective period minus one; rate 0 and 1 both give 0.
    always_comb begin
        limit = (rate == '0) ? '0 : rate - RATE_W'(1);
    end

    // Tick when the count reaches the limit while enabled.
    always_comb begin
        tick = enable && (cnt_q == limit);
    end

    // Cycle counter: clears on reset, when disabled, or on a tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable || tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + RATE_W'(1);
    end
endmodule

// File: rtl/stepper_index.sv
// Module: 3-bit half-step position register.
// Assumes one advance per cycle at most. Full mode steps to the next odd index.
module stepper_index
    import stepper_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic advance,
    input  logic dir_rev,
    input  logic half_mode,
    output idx_t idx,
    output idx_t idx_next
);
    idx_t delta;

    // Step size: 1 in half mode or from an even index in full mode, else 2.
    always_comb begin
        delta = (!half_mode && idx[0]) ? idx_t'(2) : idx_t'(1);
        idx_next = dir_rev ? idx - delta : idx + delta;
    end

    // Position register; resets to index 1.
    always_ff @(posedge clk) begin
        if (!rst_n)
            idx <= idx_t'(1);
        else if (advance)
            idx <= idx_next;
    end
endmodule

// File: rtl/stepper_phase_seq.sv
// Module: stepper motor phase sequencer (top).
// Registers an 8-bit coil pattern that changes only when a step happens.
// Assumes synchronous active-low reset.
module stepper_phase_seq
    import stepper_seq_pkg::*;
#(
    parameter int RATE_W = 8,
    parameter int COPIES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_req,
    input  logic              dir_rev,
    input  logic              half_mode,
    input  logic              auto_en,
    input  logic [RATE_W-1:0] rate,
    output logic [7:0]        coils
);
    localparam int OUT_W = COIL_W * COPIES;

    logic       auto_tick;
    logic       do_step;
    idx_t       idx;
    idx_t       idx_next;
    nib_t       nib_next;
    logic [OUT_W-1:0] pat_next;

    stepper_rate_div #(.RATE_W(RATE_W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (auto_en),
        .rate   (rate),
        .tick   (auto_tick)
    );

    // Either source makes one step; coincident sources merge into one.
    always_comb begin
        do_step = step_req | auto_tick;
    end

    stepper_index u_idx (
        .clk       (clk),
        .rst_n     (rst_n),
        .advance   (do_step),
        .dir_rev   (dir_rev),
        .half_mode (half_mode),
        .idx       (idx),
        .idx_next  (idx_next)
    );

    // Nibble for the position about to be entered.
    always_comb begin
        nib_next = coil_nibble(idx_next);
    end

    // Mirror the nibble into each output slice.
    for (genvar g = 0; g < COPIES; g++) begin : g_mirror
        assign pat_next[g*COIL_W +: COIL_W] = nib_next;
    end

    // Output register: reset pattern for index 1, updated on each step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            coils <= 8'h33;
        else if (do_step)
            coils <= pat_next[7:0];
    end
endmodule

// File: rtl/stepper_phase_seq_chk.sv
// Checker: temporal properties of the sequencer, observed at its ports.
module stepper_phase_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       step_req,
    input logic       half_mode,
    input logic       auto_en,
    input logic [7:0] coils
);
    // R1: a reset edge leaves the index-1 pattern.
    assert_reset_pattern_R1: assert property (@(posedge clk)
        !rst_n |=> coils == 8'h33);

    // R2: in half mode a step leaves a two-coil pattern for a one-coil pattern.
    assert_half_alternates_R2: assert property (@(posedge clk) disable iff (!rst_n)
        half_mode && step_req && $countones(coils) == 4 |=> $countones(coils) == 2);

    // R4: a full-mode step always lands on a two-coil pattern.
    assert_full_two_coil_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !half_mode && step_req |=> $countones(coils) == 4);

    // R7: with no step source the pattern holds.
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !step_req && !auto_en |=> $stable(coils));

    // R9: every step request changes the pattern.
    assert_step_moves_R9: assert property (@(posedge clk) disable iff (!rst_n)
        step_req |=> !$stable(coils));

    // R2: the two nibbles always match.
    assert_mirror_R2: assert property (@(posedge clk) disable iff (!rst_n)
        coils[7:4] == coils[3:0]);
endmodule

bind stepper_phase_seq stepper_phase_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_req  (step_req),
    .half_mode (half_mode),
    .auto_en   (auto_en),
    .coils     (coils)
);

// File: tb/stepper_phase_seq_test.sv
// Bench: scoreboard. The driver pushes expected patterns; the monitor pops and compares.
module stepper_phase_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int RW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          step_req = 1'b0;
    logic          dir_rev = 1'b0;
    logic          half_mode = 1'b1;
    logic          auto_en = 1'b0;
    logic [RW-1:0] rate = '0;
    logic [7:0]    coils;

    int tests = 0;
    int fails = 0;

    logic [7:0]  exp_q[$];
    string       tag_q[$];
    logic [7:0]  htab [8] = '{8'h11, 8'h33, 8'h22, 8'h66, 8'h44, 8'hCC, 8'h88, 8'h99};
    logic [2:0]  m_idx = 3'd1;
    int          auto_cnt = 0;

    stepper_phase_seq #(.RATE_W(RW)) uut (
        .clk(clk), .rst_n(rst_n), .step_req(step_req), .dir_rev(dir_rev),
        .half_mode(half_mode), .auto_en(auto_en), .rate(rate), .coils(coils)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: one comparison per pushed item, taken away from the edge.
    always @(negedge clk) begin
        if (exp_q.size() > 0)
            check(coils, exp_q.pop_front(), tag_q.pop_front());
    end

    // Model position update.
    task automatic model_step();
        int d;
        d = (!half_mode && m_idx[0]) ? 2 : 1;
        m_idx = dir_rev ? m_idx - 3'(d) : m_idx + 3'(d);
    endtask

    // Driver: apply inputs for one cycle, then push the expected result.
    task automatic cyc(input logic s, input logic dr, input logic hm, input string tag);
        logic auto_step;
        step_req = s; dir_rev = dr; half_mode = hm;
        @(posedge clk);
        auto_step = 1'b0;
        if (auto_en) begin
            int per;
            per = (rate == 0) ? 1 : int'(rate);
            auto_cnt++;
            if (auto_cnt == per) begin
                auto_step = 1'b1;
                auto_cnt = 0;
            end
        end else
            auto_cnt = 0;
        if (s || auto_step) model_step();
        exp_q.push_back(htab[m_idx]);
        tag_q.push_back(tag);
        @(negedge clk);
    endtask

    initial begin
        fork
            begin
                #(CLK_PERIOD * 20000);
                fails++; tests++;
                $display("FAIL watchdog: got timeout expected completion");
                $display("[TB] %0d tests run, %0d failed", tests, fails);
                $finish;
            end
        join_none

        repeat (3) @(negedge clk);
        check(coils, 8'h33, "R1");
        rst_n = 1'b1;

        for (int i = 0; i < 9; i++) cyc(1, 0, 1, "R2");
        for (int i = 0; i < 10; i++) cyc(1, 1, 1, "R3");
        cyc(0, 0, 1, "R3");
        // Reach index 1, then run full forward with wrap.
        while (m_idx != 3'd1) cyc(1, 0, 1, "R2");
        for (int i = 0; i < 6; i++) cyc(1, 0, 0, "R4");
        for (int i = 0; i < 6; i++) cyc(1, 1, 0, "R5");
        // Move to 0x22 (index 2) in half mode, then take a full-mode step each way.
        while (m_idx != 3'd2) cyc(1, 0, 1, "R6");
        cyc(1, 0, 0, "R6");
        check(htab[m_idx], 8'h66, "R6");
        while (m_idx != 3'd2) cyc(1, 0, 1, "R6");
        cyc(1, 1, 0, "R6");
        check(htab[m_idx], 8'h33, "R6");
        // Hold: toggle mode and direction with no step.
        cyc(0, 1, 1, "R7"); cyc(0, 0, 0, "R7"); cyc(0, 1, 0, "R7");

        rate = 8'd3; auto_en = 1'b1;
        for (int i = 0; i < 9; i++) cyc(0, 0, 1, "R8");
        auto_en = 1'b0; cyc(0, 0, 1, "R8");
        rate = 8'd2; auto_en = 1'b1;
        for (int i = 0; i < 8; i++) cyc(1, 0, 1, "R9");
        auto_en = 1'b0; cyc(0, 0, 1, "R9");
        rate = 8'd0; auto_en = 1'b1;
        for (int i = 0; i < 5; i++) cyc(0, 1, 1, "R10");
        auto_en = 1'b0; cyc(0, 0, 1, "R10");

        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        check(coils, 8'h33, "R1");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule